// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits beside a memory port that moves two 32-bit words per access. Each word carries 7 check bits under a (39,32) SECDED code. The block produces check bits for the write data of both words. It decodes both words of every read and returns the corrected data. It also records what went wrong in two software-visible registers: an error address register and an error syndrome register.

The syndrome register follows every read until a serious error latches the address register. It then holds, so software sees the read that caused the fault. The serious errors are an uncorrectable double-bit error, a timeout or an overrun. A latched address register raises the interrupt line. Software reads both registers as plain outputs. It clears either register with a one-cycle clear strobe, and a strobe wipes the whole register.

Top module: `ecc_err_capture`

## Requirements
- R1: Check bits are built from a fixed column matrix. Data bit i uses the i-th 7-bit value of weight three, in ascending numeric order: bit 0 uses 0x07 and bit 1 uses 0x0B. Check bit j is the XOR of all data bits whose column has bit j set. The low word is bits 31:0 and its check bits are 6:0. The high word is bits 63:32 and its check bits are 13:7.
- R2: A read word's syndrome is the recomputed check bits XOR the check bits read. A zero syndrome means no error. An odd-weight syndrome means a single error. A nonzero even-weight syndrome means a double error.
- R3: The corrected read data flips the data bit whose column equals an odd-weight syndrome. A single error in a check bit leaves the data unchanged.
- R4: A read with a double error in either word, or any access flagged timeout or overrun, latches the address register one cycle later, provided its valid bit is clear. The layout is valid at bit 31, CPU (1) or DMA (0) at bit 30, write (1) or read (0) at bit 29, ECC cause (1) or timeout/overrun (0) at bit 28, zero at bit 27, and the address at bits 26:0.
- R5: A single error updates its syndrome half and sets that half's valid bit, but it does not latch the address register.
- R6: Each syndrome half holds a valid bit (nonzero syndrome), the 7 check bits read, a single flag (1 for single, 0 otherwise) and the 7-bit syndrome. The high half sits at bits 31, 30:24, 23 and 22:16. The low half sits at bits 15, 14:8, 7 and 6:0. While the address valid bit is clear, every read reloads both halves. Writes never reload them.
- R7: While the address valid bit is set, the syndrome register does not change except by a clear.
- R8: The interrupt output equals the address register's valid bit.
- R9: While the address valid bit is set, further errors of any kind leave the address register unchanged.
- R10: A clear strobe zeroes its register on the next cycle. It wins over a new error or reload arriving in the same cycle, and that event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A memory access completes this cycle |
| acc_cpu | input | 1 | 1 = CPU access, 0 = DMA access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 27 | Access address |
| acc_timeout | input | 1 | Access ended in a timeout |
| acc_overrun | input | 1 | Access ended in an overrun |
| rd_word | input | 64 | Data read from memory, high word in 63:32 |
| rd_check | input | 14 | Check bits read, high word in 13:7 |
| wr_word | input | 64 | Data about to be written |
| wr_check | output | 14 | Check bits for wr_word |
| rd_fixed | output | 64 | Corrected read data |
| clr_ear | input | 1 | Clear strobe for the address register |
| clr_esr | input | 1 | Clear strobe for the syndrome register |
| ear | output | 32 | Error address register |
| esr | output | 32 | Error syndrome register |
| irq | output | 1 | Bus error interrupt request |

## Verification
The bench builds the block at the package widths the register layout fixes: 32-bit words, 7 check bits and a 27-bit address. At these widths every field lands at its programmed bit position, so expected register words can be written bit for bit. Flipping chosen data and check bits reaches single errors in a data bit and in a check bit, double errors in either word, the frozen state, and the clear-versus-error collision.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int ADDR_W = 27;
    localparam int HALVES = 2;
    localparam int COL_WT = 3;

    typedef logic [CHK_W-1:0] chk_t;
    typedef logic [DATA_W-1:0][CHK_W-1:0] hmat_t;

    typedef struct packed {
        logic              valid;
        logic              cpu;
        logic              wr;
        logic              eccerr;
        logic              spare;
        logic [ADDR_W-1:0] addr;
    } ear_t;

    typedef struct packed {
        logic valid;
        chk_t chk;
        logic single;
        chk_t syn;
    } esr_half_t;

    typedef struct packed {
        esr_half_t hi;
        esr_half_t lo;
    } esr_t;

    typedef struct packed {
        ear_t ear;
        esr_t esr;
    } cap_state_t;

    // Column i of the parity matrix: i-th weight-three value in ascending order.
    function automatic hmat_t build_h();
        hmat_t m = '0;
        int    n = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(v[CHK_W-1:0]) == COL_WT && n < DATA_W) begin
                m[n] = v[CHK_W-1:0];
                n++;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_cap_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output chk_t              chk_o
);
    localparam hmat_t H = build_h();

    always_comb begin
        chk_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) chk_o = chk_o ^ H[i];
        end
    end
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_cap_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  chk_t              chk_i,
    output chk_t              syn_o,
    output logic              single_o,
    output logic              double_o,
    output logic [DATA_W-1:0] data_o
);
    localparam hmat_t H = build_h();

    chk_t recomputed;

    ecc_secded_enc u_enc (
        .data_i (data_i),
        .chk_o  (recomputed)
    );

    always_comb begin
        syn_o    = recomputed ^ chk_i;
        single_o = ^syn_o;
        double_o = (syn_o != '0) && !single_o;
        for (int i = 0; i < DATA_W; i++) begin
            data_o[i] = data_i[i] ^ (single_o && (syn_o == H[i]));
        end
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_cpu,
    input  logic                       acc_write,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic                       acc_timeout,
    input  logic                       acc_overrun,
    input  logic [HALVES*DATA_W-1:0]   rd_word,
    input  logic [HALVES*CHK_W-1:0]    rd_check,
    input  logic [HALVES*DATA_W-1:0]   wr_word,
    output logic [HALVES*CHK_W-1:0]    wr_check,
    output logic [HALVES*DATA_W-1:0]   rd_fixed,
    input  logic                       clr_ear,
    input  logic                       clr_esr,
    output logic [31:0]                ear,
    output logic [31:0]                esr,
    output logic                       irq
);
    chk_t              syn   [HALVES];
    logic [HALVES-1:0] sng;
    logic [HALVES-1:0] dbl;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ecc_secded_enc u_wenc (
            .data_i (wr_word[h*DATA_W +: DATA_W]),
            .chk_o  (wr_check[h*CHK_W +: CHK_W])
        );
        ecc_secded_dec u_dec (
            .data_i   (rd_word[h*DATA_W +: DATA_W]),
            .chk_i    (rd_check[h*CHK_W +: CHK_W]),
            .syn_o    (syn[h]),
            .single_o (sng[h]),
            .double_o (dbl[h]),
            .data_o   (rd_fixed[h*DATA_W +: DATA_W])
        );
    end

    cap_state_t st_d, st_q;
    esr_half_t  half_new [HALVES];
    logic       rd_acc;
    logic       dbl_read;
    logic       err_evt;

    always_comb begin
        st_d     = st_q;
        rd_acc   = acc_valid && !acc_write;
        dbl_read = rd_acc && (|dbl);
        err_evt  = acc_valid && (dbl_read || acc_timeout || acc_overrun);

        for (int h = 0; h < HALVES; h++) begin
            half_new[h].valid  = (syn[h] != '0);
            half_new[h].chk    = rd_check[h*CHK_W +: CHK_W];
            half_new[h].single = sng[h];
            half_new[h].syn    = syn[h];
        end

        if (!st_q.ear.valid && err_evt) begin
            st_d.ear.valid  = 1'b1;
            st_d.ear.cpu    = acc_cpu;
            st_d.ear.wr     = acc_write;
            st_d.ear.eccerr = dbl_read;
            st_d.ear.spare  = 1'b0;
            st_d.ear.addr   = acc_addr;
        end
        if (clr_ear) st_d.ear = '0;

        if (!st_q.ear.valid && rd_acc) begin
            st_d.esr.hi = half_new[1];
            st_d.esr.lo = half_new[0];
        end
        if (clr_esr) st_d.esr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ear = st_q.ear;
    assign esr = st_q.esr;
    assign irq = st_q.ear.valid;

    assert_latch_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_timeout || acc_overrun) && !st_q.ear.valid && !clr_ear)
        |=> (st_q.ear.valid && !st_q.ear.eccerr));

    assert_single_no_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ear.valid && !(acc_valid && (acc_timeout || acc_overrun)) && !(|dbl))
        |=> !st_q.ear.valid);

    assert_esr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ear.valid && !clr_esr) |=> $stable(st_q.esr));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(acc_valid));

    assert_drop_later_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ear.valid && !clr_ear) |=> $stable(st_q.ear));

    assert_clear_ear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ear |=> (st_q.ear == '0));

    assert_clear_esr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_esr |=> (st_q.esr == '0));
endmodule

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
    localparam int DW = 32;
    localparam int CW = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_cpu = 0, acc_write = 0, acc_timeout = 0, acc_overrun = 0;
    logic [26:0] acc_addr = '0;
    logic [63:0] rd_word = '0, wr_word = '0;
    logic [13:0] rd_check = '0;
    logic        clr_ear = 0, clr_esr = 0;
    logic [13:0] wr_check;
    logic [63:0] rd_fixed;
    logic [31:0] ear, esr;
    logic        irq;

    always #10 clk = ~clk;

    ecc_err_capture u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_cpu(acc_cpu),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_timeout(acc_timeout),
        .acc_overrun(acc_overrun), .rd_word(rd_word), .rd_check(rd_check),
        .wr_word(wr_word), .wr_check(wr_check), .rd_fixed(rd_fixed),
        .clr_ear(clr_ear), .clr_esr(clr_esr), .ear(ear), .esr(esr), .irq(irq)
    );

    typedef struct {
        logic [31:0] ear;
        logic [31:0] esr;
        string       tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] col [DW];
    logic [31:0] mear = '0, mesr = '0;

    initial begin
        int n;
        n = 0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v[6:0]) == 3 && n < DW) begin
                col[n] = v[6:0];
                n++;
            end
        end
    end

    function automatic logic [6:0] enc(logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < DW; i++) if (d[i]) c = c ^ col[i];
        return c;
    endfunction

    function automatic logic [13:0] cw(logic [63:0] d);
        return {enc(d[63:32]), enc(d[31:0])};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one access per cycle, predicts registers, queues the prediction
    task automatic cyc(string tag, logic v, logic cpu, logic wr, logic [26:0] a,
                       logic to, logic ov, logic [63:0] d, logic [13:0] c,
                       logic [63:0] good, logic cear, logic cesr);
        logic [6:0]  s [2];
        logic [1:0]  sg, db;
        logic        rd;
        logic [31:0] ne, ns;
        exp_t        e;
        @(negedge clk);
        acc_valid = v; acc_cpu = cpu; acc_write = wr; acc_addr = a;
        acc_timeout = to; acc_overrun = ov; rd_word = d; rd_check = c;
        wr_word = d; clr_ear = cear; clr_esr = cesr;
        rd = v && !wr;
        for (int h = 0; h < 2; h++) begin
            s[h]  = enc(d[h*32 +: 32]) ^ c[h*7 +: 7];
            sg[h] = ^s[h];
            db[h] = (s[h] != 0) && !sg[h];
        end
        ne = mear;
        ns = mesr;
        if (!mear[31] && v && ((rd && |db) || to || ov))
            ne = {1'b1, cpu, wr, rd && |db, 1'b0, a};
        if (cear) ne = '0;
        if (!mear[31] && rd)
            ns = {s[1] != 0, c[13:7], sg[1], s[1], s[0] != 0, c[6:0], sg[0], s[0]};
        if (cesr) ns = '0;
        mear = ne;
        mesr = ns;
        #1;
        chk({tag, " R1 wr_check"}, 64'(wr_check), 64'(cw(d)));
        if (rd && !(|db)) chk({tag, " R3 rd_fixed"}, rd_fixed, good);
        e.ear = ne; e.esr = ns; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares each queued prediction after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " ear"}, 64'(ear), 64'(e.ear));
                chk({e.tag, " esr"}, 64'(esr), 64'(e.esr));
                chk({e.tag, " R8 irq"}, 64'(irq), 64'(e.ear[31]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [63:0] D  = 64'h1234_5678_A5A5_0F0F;
    localparam logic [63:0] D2 = 64'hDEAD_BEEF_0000_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        chk("reset ear", 64'(ear), 64'h0);
        chk("reset esr", 64'(esr), 64'h0);
        chk("reset R8 irq", 64'(irq), 64'h0);
        rst_n = 1'b1;

        // R1: fixed columns for data bit 0 (0x07) and bit 1 (0x0B)
        @(negedge clk);
        wr_word = 64'h0000_0002_0000_0001;
        #1;
        chk("R1 column literal", 64'(wr_check), 64'({7'h0B, 7'h07}));

        cyc("R6 clean read", 1, 1, 0, 27'h100, 0, 0, D, cw(D), D, 0, 0);
        cyc("R5 R2 single lo data", 1, 1, 0, 27'h104, 0, 0, D ^ (64'd1 << 5), cw(D), D, 0, 0);
        cyc("R5 R3 single hi check", 1, 0, 0, 27'h108, 0, 0, D, cw(D) ^ (14'd1 << 9), D, 0, 0);
        cyc("R6 write no reload", 1, 1, 1, 27'h10C, 0, 0, D2 ^ 64'h3, cw(D2), D2, 0, 0);
        cyc("R4 R2 double hi", 1, 1, 0, 27'h5ABCDE, 0, 0, D2 ^ (64'h3 << 40), cw(D2), D2, 0, 0);
        cyc("R7 R9 frozen single", 1, 0, 0, 27'h200, 0, 0, D ^ (64'd1 << 50), cw(D), D, 0, 0);
        cyc("R9 timeout dropped", 1, 0, 1, 27'h300, 1, 0, D, cw(D), D, 0, 0);
        cyc("R10 clear esr only", 0, 0, 0, 27'h0, 0, 0, D, cw(D), D, 0, 1);
        cyc("R7 still frozen", 1, 1, 0, 27'h204, 0, 0, D ^ (64'd1 << 7), cw(D), D, 0, 0);
        cyc("R10 clear ear", 0, 0, 0, 27'h0, 0, 0, D, cw(D), D, 1, 0);
        cyc("R6 idle", 0, 0, 0, 27'h0, 0, 0, D, cw(D), D, 0, 0);
        cyc("R4 timeout dma write", 1, 0, 1, 27'h7FFFFFF, 1, 0, D, cw(D), D, 0, 0);
        cyc("R10 clear both", 0, 0, 0, 27'h0, 0, 0, D, cw(D), D, 1, 1);
        cyc("R10 clear beats overrun", 1, 1, 0, 27'h44, 0, 1, D, cw(D), D, 1, 0);
        cyc("R4 overrun read", 1, 1, 0, 27'h48, 0, 1, D2, cw(D2), D2, 0, 0);
        cyc("R10 clear both again", 0, 0, 0, 27'h0, 0, 0, D, cw(D), D, 1, 1);
        cyc("R4 double lo", 1, 0, 0, 27'h1234, 0, 0, D ^ 64'h11, cw(D), D, 0, 0);
        cyc("R10 clear esr beats frozen", 1, 1, 0, 27'h10, 0, 0, D, cw(D), D, 0, 1);
        cyc("R6 idle end", 0, 0, 0, 27'h0, 0, 0, D, cw(D), D, 0, 0);

        while (q.size() > 0) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule